// File: doc/BRIEF.md
# SDI Receiver Rate-Search Controller

This controller lets one serial video receiver lock onto either a high-definition or a standard-definition stream without reconfiguring the transceiver. It tries one rate at a time. For each attempt it resets the receive path, waits through a settle window, and then waits for the downstream decoder to report a valid signal. If no valid signal arrives within a fixed timeout, it switches to the other rate. After reset the search starts at the high-definition rate, and it keeps alternating between the two rates for as long as no signal is found.

At the high rate the receive PLL first trains on the reference clock. It switches to tracking the incoming data only after lock is reported. If tracking runs too long without a valid signal, the PLL is sent back to training. At the standard rate the data are recovered by fixed oversampling, so the PLL stays on the reference clock for the whole attempt.

While the high-rate PLL is tracking, the controller counts runs of identical bits across the recovered parallel words. A run that reaches the illegal length is treated as a false lock: the receive path is reset and the PLL retrains. A loss of signal-valid while locked restarts the whole search at the high rate.

Top module: `sdi_rate_hunt`

## Requirements
- R1: While `rst_n` is low, `rx_reset`=1, `rate_hd`=1 (high-definition), `pll_track`=0 (train on reference) and `link_up`=0.
- R2: Every receive reset started by the controller holds `rx_reset` high for exactly RST_CYC cycles. After `rst_n` is released, `rx_reset` stays high for RST_CYC-1 more cycles. `pll_locked` and `sig_valid` are ignored while `rx_reset` is high and for the SETTLE_CYC cycles that follow.
- R3: At the high rate, `pll_track` stays 0 after the settle window until `pll_locked` is seen high, and it goes to 1 in the next cycle. With `pll_locked` low it never rises.
- R4: At the standard rate (`rate_hd`=0), `pll_track` is always 0, whatever the value of `pll_locked`.
- R5: An attempt lasts TMO_CYC cycles from the end of the settle window. If `sig_valid` is not seen in that time, `rx_reset` rises and `rate_hd` toggles at the same moment. The rates alternate with no limit.
- R6: Once the settle window ends, `link_up` rises in the cycle after `sig_valid` is seen. It stays high only while `sig_valid` stays high.
- R7: When `sig_valid` falls while `link_up`=1, `rx_reset` rises in the next cycle and `rate_hd` becomes 1, whichever rate was locked.
- R8: At the high rate, after RETRAIN_CYC tracking cycles with no `sig_valid`, `pll_track` returns to 0 (training) without asserting `rx_reset`. The train/track sequence then repeats.
- R9: While the high-rate PLL tracks, a run of RUN_LIMIT identical bits asserts `rx_reset` in the next cycle and keeps `rate_hd`=1. Bit 0 of `rx_word` is the earliest bit, and a run continues across word boundaries. Runs of up to RUN_LIMIT-1 bits have no effect.
- R10: At the standard rate, runs of identical bits of any length have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | Receive PLL lock indication |
| sig_valid | input | 1 | Signal-valid flag from the downstream decoder |
| rx_word | input | WORD_W | Recovered parallel word, bit 0 earliest |
| rx_reset | output | 1 | Receive-path reset |
| pll_track | output | 1 | 1: PLL tracks data, 0: PLL trains on reference |
| rate_hd | output | 1 | Rate being tried: 1 high definition, 0 standard |
| link_up | output | 1 | Signal valid within the current attempt |

## Verification
Lock and valid are each held high, held low, or pulsed so that every path out of an attempt is taken. Constant high inputs during reset separate "ignored while settling" from "acted on early". Lock held low against lock held high at each rate separates the high-rate training gate from the fixed reference mode of the standard rate. Random run lengths below the limit, a forced run of one less than the limit and a forced run at the limit are checked word by word against a bench run model, which shows both where the trip threshold sits and that runs carry across words. All-zero words at the standard rate show that the run check is limited to the high rate.

// File: rtl/sdi_rate_hunt.sv
module sdi_rate_hunt #(
  parameter int CLK_HZ      = 148_500_000,
  parameter int TMO_CYC     = CLK_HZ / 10,
  parameter int RETRAIN_CYC = CLK_HZ / 100,
  parameter int RST_CYC     = 64,
  parameter int SETTLE_CYC  = 32,
  parameter int WORD_W      = 20,
  parameter int RUN_LIMIT   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_locked,
  input  logic              sig_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic              rx_reset,
  output logic              pll_track,
  output logic              rate_hd,
  output logic              link_up
);

  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int DW = $clog2(RETRAIN_CYC + 1);
  localparam int CMAX = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int CW = $clog2(CMAX + 1);
  localparam int NW = $clog2(RUN_LIMIT + 1);

  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);
  localparam logic [DW-1:0] DRY_LAST = DW'(RETRAIN_CYC - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [NW-1:0] RUN_MAX  = NW'(RUN_LIMIT);

  typedef enum logic [2:0] {ST_RST, ST_SETTLE, ST_TRAIN, ST_HUNT, ST_UP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] att;
  logic [DW-1:0] dry;
  logic [NW-1:0] run_q, run_d;
  logic          bit_q, bit_d, run_hit;
  logic          hd_trk, trip;

  assign hd_trk    = rate_hd && (st == ST_HUNT || st == ST_UP);
  assign trip      = hd_trk && run_hit;
  assign rx_reset  = (st == ST_RST);
  assign link_up   = (st == ST_UP);
  assign pll_track = hd_trk;

  always_comb begin
    run_d   = run_q;
    bit_d   = bit_q;
    run_hit = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (rx_word[i] == bit_d && run_d != '0) begin
        if (run_d != RUN_MAX) run_d = run_d + 1'b1;
      end else begin
        run_d = NW'(1);
      end
      bit_d = rx_word[i];
      if (run_d == RUN_MAX) run_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      bit_q <= 1'b0;
    end else if (hd_trk) begin
      run_q <= run_d;
      bit_q <= bit_d;
    end else begin
      run_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RST;
      cnt     <= '0;
      att     <= '0;
      dry     <= '0;
      rate_hd <= 1'b1;
    end else begin
      case (st)
        ST_RST: begin
          if (cnt == RST_LAST) begin
            st  <= ST_SETTLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt == SET_LAST) begin
            st  <= rate_hd ? ST_TRAIN : ST_HUNT;
            cnt <= '0;
            att <= '0;
            dry <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TRAIN: begin
          att <= att + 1'b1;
          if (att == TMO_LAST) begin
            st      <= ST_RST;
            rate_hd <= ~rate_hd;
          end else if (pll_locked) begin
            st  <= ST_HUNT;
            dry <= '0;
          end
        end
        ST_HUNT: begin
          att <= att + 1'b1;
          dry <= dry + 1'b1;
          if (trip) begin
            st <= ST_RST;
          end else if (sig_valid) begin
            st <= ST_UP;
          end else if (att == TMO_LAST) begin
            st      <= ST_RST;
            rate_hd <= ~rate_hd;
          end else if (rate_hd && dry == DRY_LAST) begin
            st  <= ST_TRAIN;
            dry <= '0;
          end
        end
        ST_UP: begin
          if (trip || !sig_valid) begin
            st      <= ST_RST;
            rate_hd <= 1'b1;
          end
        end
        default: st <= ST_RST;
      endcase
    end
  end

endmodule

// File: rtl/sdi_rate_hunt_chk.sv
module sdi_rate_hunt_chk #(
  parameter int RST_CYC = 64
) (
  input logic clk,
  input logic rst_n,
  input logic pll_locked,
  input logic sig_valid,
  input logic rx_reset,
  input logic pll_track,
  input logic rate_hd,
  input logic link_up
);

  int unsigned hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi <= 0;
    else if (rx_reset) hi <= hi + 1;
    else hi <= 0;
  end

  a_r2_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_reset) |-> hi >= RST_CYC - 1);

  a_r2_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_reset) |-> !link_up && !pll_track);

  a_r3_track_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_track) |-> $past(pll_locked));

  a_r4_sd_no_track: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_hd |-> !pll_track);

  a_r6_up_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> $past(sig_valid));

  a_r7_drop_restart: assert property (@(posedge clk) disable iff (!rst_n)
    link_up && !sig_valid |=> rx_reset && rate_hd);

endmodule

bind sdi_rate_hunt sdi_rate_hunt_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .sig_valid(sig_valid),
  .rx_reset(rx_reset), .pll_track(pll_track), .rate_hd(rate_hd), .link_up(link_up)
);

// File: tb/sim_sdi_rate_hunt.sv
`timescale 1ns/1ps
module sim_sdi_rate_hunt;
  localparam int T  = 200;
  localparam int R  = 40;
  localparam int RS = 4;
  localparam int S  = 3;
  localparam int W  = 10;
  localparam int RL = 100;
  localparam logic [W-1:0] ALT = 10'b0101010101;

  logic clk = 1'b0;
  logic rst_n, pll_locked, sig_valid;
  logic [W-1:0] rx_word;
  logic rx_reset, pll_track, rate_hd, link_up;

  always #2.5 clk = ~clk;

  sdi_rate_hunt #(.TMO_CYC(T), .RETRAIN_CYC(R), .RST_CYC(RS), .SETTLE_CYC(S),
                  .WORD_W(W), .RUN_LIMIT(RL)) u0 (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .sig_valid(sig_valid),
    .rx_word(rx_word), .rx_reset(rx_reset), .pll_track(pll_track),
    .rate_hd(rate_hd), .link_up(link_up));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int brun, rem, force_len;
  logic bbit, cur;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall(output int highs);
    highs = 0;
    while (rx_reset && highs < 10000) begin highs++; @(negedge clk); end
  endtask

  task automatic gap_rise(output int lows, output int trk);
    lows = 0; trk = 0;
    while (!rx_reset && lows < 10000) begin
      lows++;
      if (pll_track) trk++;
      @(negedge clk);
    end
  endtask

  task automatic gen_word(output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      if (rem == 0) begin
        cur = ~cur;
        if (force_len != 0) begin rem = force_len; force_len = 0; end
        else rem = int'($urandom_range(99, 1));
      end
      w[i] = cur;
      rem--;
    end
  endtask

  task automatic model_word(input logic [W-1:0] w, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (w[i] == bbit) brun++; else brun = 1;
      bbit = w[i];
      if (brun >= RL) hit = 1'b1;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int h, l, t, n, bad, run1, gp, run2, rst_seen;
    bit hit, got;
    logic [W-1:0] w;
    void'($urandom(32'h1d5));
    rst_n = 1'b0; pll_locked = 1'b1; sig_valid = 1'b1; rx_word = ALT;
    repeat (3) begin
      @(negedge clk);
      chk("R1 rx_reset", int'(rx_reset), 1);
      chk("R1 rate_hd", int'(rate_hd), 1);
      chk("R1 pll_track", int'(pll_track), 0);
      chk("R1 link_up", int'(link_up), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    wait_fall(h);
    chk("R2 power-on reset length", h, RS - 1);
    n = 0;
    while (!pll_track && n < 1000) begin n++; @(negedge clk); end
    chk("R3 cycles to track (R2 settle ignores lock)", n, S + 1);
    chk("R6 no link in track cycle", int'(link_up), 0);
    @(negedge clk);
    chk("R6 link_up after valid", int'(link_up), 1);
    bad = 0;
    repeat (5) begin @(negedge clk); if (!link_up) bad++; end
    chk("R6 link_up holds", bad, 0);

    sig_valid = 1'b0; pll_locked = 1'b0;
    @(negedge clk);
    chk("R7 reset after drop", int'(rx_reset), 1);
    chk("R7 restart at HD", int'(rate_hd), 1);
    chk("R6 link_up drops", int'(link_up), 0);
    wait_fall(h);
    chk("R2 reset length", h, RS);
    gap_rise(l, t);
    chk("R5 HD attempt length", l, S + T);
    chk("R3 no track without lock", t, 0);
    chk("R5 switch to SD", int'(rate_hd), 0);

    pll_locked = 1'b1;
    wait_fall(h);
    chk("R2 reset length SD", h, RS);
    gap_rise(l, t);
    chk("R5 SD attempt length", l, S + T);
    chk("R4 SD never tracks", t, 0);
    chk("R5 back to HD", int'(rate_hd), 1);

    pll_locked = 1'b0;
    wait_fall(h);
    gap_rise(l, t);
    chk("R5 alternates to SD again", int'(rate_hd), 0);
    wait_fall(h);
    sig_valid = 1'b1;
    n = 0;
    while (!link_up && n < 1000) begin
      if (pll_track) bad++;
      n++; @(negedge clk);
    end
    chk("R6 SD link cycles", n, S + 1);
    chk("R4 SD track off when locked", int'(pll_track), 0);
    chk("R6 SD rate", int'(rate_hd), 0);

    rx_word = '0;
    bad = 0;
    repeat (150) begin @(negedge clk); if (!link_up || rx_reset) bad++; end
    chk("R10 SD long run ignored", bad, 0);
    rx_word = ALT;

    sig_valid = 1'b0;
    @(negedge clk);
    chk("R7 SD drop resets", int'(rx_reset), 1);
    chk("R7 SD drop restarts HD", int'(rate_hd), 1);
    wait_fall(h);

    pll_locked = 1'b1;
    n = 0; rst_seen = 0;
    while (!pll_track && n < 1000) begin n++; @(negedge clk); end
    run1 = 0;
    while (pll_track && run1 < 1000) begin run1++; if (rx_reset) rst_seen++; @(negedge clk); end
    gp = 0;
    while (!pll_track && gp < 1000) begin gp++; if (rx_reset) rst_seen++; @(negedge clk); end
    run2 = 0;
    while (pll_track && run2 < 1000) begin run2++; if (rx_reset) rst_seen++; @(negedge clk); end
    chk("R8 first track span", run1, R);
    chk("R8 retrain gap", gp, 1);
    chk("R8 second track span", run2, R);
    chk("R8 no reset on retrain", rst_seen, 0);
    gap_rise(l, t);
    chk("R5 HD timeout with retrains", int'(rate_hd), 0);
    pll_locked = 1'b0;
    wait_fall(h);
    gap_rise(l, t);
    wait_fall(h);
    pll_locked = 1'b1; sig_valid = 1'b1;
    n = 0;
    while (!link_up && n < 1000) begin n++; @(negedge clk); end
    chk("R9 HD link before run test", int'(link_up & rate_hd), 1);

    bbit = 1'b0; brun = 1; cur = 1'b0; rem = 0; force_len = 0;
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      gen_word(w); model_word(w, hit);
      rx_word = w;
      @(negedge clk);
      if (int'(rx_reset) != int'(hit) || int'(link_up) != int'(!hit)) bad++;
      if (hit) break;
    end
    chk("R9 random legal runs no reset", bad, 0);
    force_len = 99; bad = 0;
    for (int k = 0; k < 40; k++) begin
      gen_word(w); model_word(w, hit);
      rx_word = w;
      @(negedge clk);
      if (int'(rx_reset) != int'(hit)) bad++;
      if (hit) break;
    end
    chk("R9 run of limit-1 no reset", bad, 0);
    force_len = 100; got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      gen_word(w); model_word(w, hit);
      rx_word = w;
      @(negedge clk);
      if (hit) begin
        got = 1'b1;
        chk("R9 run at limit resets", int'(rx_reset), 1);
        chk("R9 stays HD", int'(rate_hd), 1);
        break;
      end else if (rx_reset) begin
        chk("R9 early reset", int'(rx_reset), 0);
      end
    end
    chk("R9 limit run produced", int'(got), 1);
    rx_word = ALT;
    wait_fall(h);
    chk("R2 reset length after trip", h, RS);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule